// File: doc/BRIEF.md
# Parallel memory read controller

This block sits on the host side of a bank of asynchronous byte-wide memories that share one address bus and one data bus. The host asks for a single byte with a level request and an address. The controller drives the address, pulls low the chip enable of the one device that the top address bits select, and pulls the shared output enable low only once enough of the access time has passed. It samples the data bus when both the address/enable access time and the output-enable access time are met. It then returns the byte with a one-cycle acknowledge.

Chip enables are decoded per device, so every device that is not addressed stays in standby. The output enable is common to all devices and behaves as the system read strobe. When a read finishes, both enables rise together. The controller then holds off the next access until the data drivers of the device just read have had time to float. All three analogue times are given in nanoseconds and are turned into whole clock cycles, rounding up, from the clock period parameter.

Top module: `pmem_rd_ctrl`

## Requirements
- R1: While reset is low, every chip enable and the output enable are high (inactive) and the acknowledge is low.
- R2: For an accepted request, only the chip enable whose index equals address bits [19:18] goes low, the memory address equals address bits [17:0], and both stay unchanged from the falling of that enable until it rises.
- R3: Each delay is the nanosecond value divided by the clock period, rounded up: access time ACC, output-enable time OE (both at least 1) and float time FLT.
- R4: The output enable goes low exactly GATE = max(ACC - OE, 0) cycles after the chip enable falls, and never while all chip enables are high.
- R5: The data bus is sampled at the clock edge CAP = max(ACC, OE) cycles after the chip enable falls. The acknowledge is high for exactly one cycle after that edge, carrying the sampled byte.
- R6: The chip enable and the output enable rise at the same edge that samples the data, so both are already high in the cycle in which the acknowledge is high.
- R7: After the enables rise, no chip enable falls for at least FLT+1 cycles. When a request is already waiting, the next chip enable falls after exactly FLT+1 cycles (for FLT of 1 or more).
- R8: The returned byte and the memory address keep their last values until the next read completes or is accepted.
- R9: With the request low, no chip enable or output enable is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Read request, held until acknowledge |
| addr_i | input | 20 | Byte address; bits [19:18] pick the device |
| ack_o | output | 1 | One-cycle read-done pulse |
| rdata_o | output | 8 | Byte returned by the last read |
| mem_addr_o | output | 18 | Address bus to all devices |
| mem_ce_n_o | output | 4 | Active-low chip enable, one per device |
| mem_oe_n_o | output | 1 | Active-low output enable shared by all devices |
| mem_data_i | input | 8 | Data bus from the devices |

## Verification
The bench builds the block with an 8 ns clock and with 120, 50 and 40 ns timings. This gives ACC=15, OE=7 (50/8 rounded up) and FLT=5, so the output enable trails the chip enable by a nonzero gap of 8 cycles. The memory model in the bench returns the true byte only when its own counters show that both access windows have elapsed, so sampling one cycle early is visible. Back-to-back requests make the exact float gap observable, and reads to the lowest and highest addresses of every device exercise the enable decode.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SEL  = 2'd1,
        PH_GATE = 2'd2,
        PH_REC  = 2'd3
    } phase_e;

    // Nanoseconds to whole clock cycles, rounding up.
    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max_u(input int unsigned a,
                                          input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pmem_dev_decode.sv
module pmem_dev_decode #(
    parameter int unsigned DEV_W = 2,
    localparam int unsigned NDEV = 1 << DEV_W
) (
    input  logic             en_i,
    input  logic [DEV_W-1:0] sel_i,
    output logic [NDEV-1:0]  ce_n_o
);

    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        assign ce_n_o[g] = !(en_i && (sel_i == DEV_W'(g)));
    end

endmodule

// File: rtl/pmem_rd_seq.sv
module pmem_rd_seq
    import pmem_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned DEV_W    = 2,
    parameter int unsigned GATE_CYC = 8,
    parameter int unsigned CAP_CYC  = 15,
    parameter int unsigned FLT_CYC  = 5,
    parameter int unsigned CNT_W    = 5,
    localparam int unsigned NDEV    = 1 << DEV_W,
    localparam int unsigned MADDR_W = ADDR_W - DEV_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic               cap_o,
    output logic [NDEV-1:0]    ce_n_o,
    output logic               oe_n_o,
    output logic [MADDR_W-1:0] maddr_o
);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [DEV_W-1:0]   dev;
        logic [MADDR_W-1:0] maddr;
        logic               ce_act;
        logic               oe_act;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             cap_d;
    logic [NDEV-1:0]  ce_n_d, ce_n_q;

    assign cnt_nx = seq_q.cnt + 1'b1;

    always_comb begin
        seq_d = seq_q;
        cap_d = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    seq_d.dev    = addr_i[ADDR_W-1 -: DEV_W];
                    seq_d.maddr  = addr_i[MADDR_W-1:0];
                    seq_d.ce_act = 1'b1;
                    seq_d.cnt    = '0;
                    if (GATE_CYC == 0) begin
                        seq_d.oe_act = 1'b1;
                        seq_d.phase  = PH_GATE;
                    end else begin
                        seq_d.phase  = PH_SEL;
                    end
                end
            end
            PH_SEL: begin
                seq_d.cnt = cnt_nx;
                if (cnt_nx >= CNT_W'(GATE_CYC)) begin
                    seq_d.oe_act = 1'b1;
                    seq_d.phase  = PH_GATE;
                end
            end
            PH_GATE: begin
                seq_d.cnt = cnt_nx;
                if (cnt_nx >= CNT_W'(CAP_CYC)) begin
                    cap_d        = 1'b1;
                    seq_d.ce_act = 1'b0;
                    seq_d.oe_act = 1'b0;
                    seq_d.cnt    = '0;
                    seq_d.phase  = PH_REC;
                end
            end
            PH_REC: begin
                seq_d.cnt = cnt_nx;
                if (cnt_nx >= CNT_W'(FLT_CYC)) begin
                    seq_d.cnt   = '0;
                    seq_d.phase = PH_IDLE;
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    // Enables are decoded from next-state values and registered, so pins never glitch.
    pmem_dev_decode #(
        .DEV_W (DEV_W)
    ) dec_i (
        .en_i   (seq_d.ce_act),
        .sel_i  (seq_d.dev),
        .ce_n_o (ce_n_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= '{phase: PH_IDLE, cnt: '0, dev: '0, maddr: '0,
                        ce_act: 1'b0, oe_act: 1'b0};
            ce_n_q <= '1;
        end else begin
            seq_q  <= seq_d;
            ce_n_q <= ce_n_d;
        end
    end

    assign cap_o   = cap_d;
    assign ce_n_o  = ce_n_q;
    assign oe_n_o  = !seq_q.oe_act;
    assign maddr_o = seq_q.maddr;

    // R2
    one_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n_q));

    // R4
    oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n_o |-> !(&ce_n_q));

endmodule

// File: rtl/pmem_rd_capture.sv
module pmem_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.ack = cap_i;
        if (cap_i) begin
            cap_d.data = bus_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign ack_o   = cap_q.ack;
    assign rdata_o = cap_q.data;

    // R5
    ack_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.ack |=> !cap_q.ack);

endmodule

// File: rtl/pmem_rd_ctrl.sv
module pmem_rd_ctrl
    import pmem_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DEV_W  = 2,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CLK_NS = 10,
    parameter int unsigned ACC_NS = 120,
    parameter int unsigned OE_NS  = 50,
    parameter int unsigned FLT_NS = 40,
    localparam int unsigned NDEV     = 1 << DEV_W,
    localparam int unsigned MADDR_W  = ADDR_W - DEV_W,
    localparam int unsigned ACC_CYC  = max_u(ns_to_cyc(ACC_NS, CLK_NS), 1),
    localparam int unsigned OE_CYC   = max_u(ns_to_cyc(OE_NS, CLK_NS), 1),
    localparam int unsigned FLT_CYC  = ns_to_cyc(FLT_NS, CLK_NS),
    localparam int unsigned GATE_CYC = (ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0,
    localparam int unsigned CAP_CYC  = max_u(ACC_CYC, OE_CYC),
    localparam int unsigned CNT_W    = $clog2(CAP_CYC + FLT_CYC + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic               ack_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [MADDR_W-1:0] mem_addr_o,
    output logic [NDEV-1:0]    mem_ce_n_o,
    output logic               mem_oe_n_o,
    input  logic [DATA_W-1:0]  mem_data_i
);

    logic cap;

    pmem_rd_seq #(
        .ADDR_W   (ADDR_W),
        .DEV_W    (DEV_W),
        .GATE_CYC (GATE_CYC),
        .CAP_CYC  (CAP_CYC),
        .FLT_CYC  (FLT_CYC),
        .CNT_W    (CNT_W)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .addr_i  (addr_i),
        .cap_o   (cap),
        .ce_n_o  (mem_ce_n_o),
        .oe_n_o  (mem_oe_n_o),
        .maddr_o (mem_addr_o)
    );

    pmem_rd_capture #(
        .DATA_W (DATA_W)
    ) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (cap),
        .bus_i   (mem_data_i),
        .ack_o   (ack_o),
        .rdata_o (rdata_o)
    );

    // Checker state: how long the pins have held each enable low.
    logic             ce_low, ce_low_q;
    logic [CNT_W-1:0] ce_run_d, ce_run_q, oe_run_d, oe_run_q;

    assign ce_low = !(&mem_ce_n_o);

    always_comb begin
        ce_run_d = ce_low ? ((&ce_run_q) ? ce_run_q : ce_run_q + 1'b1) : '0;
        oe_run_d = !mem_oe_n_o ? ((&oe_run_q) ? oe_run_q : oe_run_q + 1'b1) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_run_q <= '0;
            oe_run_q <= '0;
            ce_low_q <= 1'b0;
        end else begin
            ce_run_q <= ce_run_d;
            oe_run_q <= oe_run_d;
            ce_low_q <= ce_low;
        end
    end

    // R5
    acc_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (ce_run_q >= CNT_W'(ACC_CYC) && oe_run_q >= CNT_W'(OE_CYC)));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (&mem_ce_n_o && mem_oe_n_o && ce_low_q));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_low && ce_low_q) |-> ($stable(mem_addr_o) && $stable(mem_ce_n_o)));

endmodule

// File: tb/pmem_rd_ctrl_tb_top.sv
module pmem_rd_ctrl_tb_top;

    localparam int CLK_PERIOD = 8;
    localparam int ACC_NS = 120, OE_NS = 50, FLT_NS = 40;
    // R3: expected cycle counts, rounded up
    localparam int ACC  = (ACC_NS + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int OE   = (OE_NS + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int FLT  = (FLT_NS + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int GATE = (ACC > OE) ? ACC - OE : 0;
    localparam int CAP  = (ACC > OE) ? ACC : OE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [19:0] addr = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic [17:0] mem_addr;
    logic [3:0]  mem_ce_n;
    logic        mem_oe_n;
    logic [7:0]  mem_data;

    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmem_rd_ctrl #(
        .CLK_NS (CLK_PERIOD),
        .ACC_NS (ACC_NS),
        .OE_NS  (OE_NS),
        .FLT_NS (FLT_NS)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .addr_i     (addr),
        .ack_o      (ack),
        .rdata_o    (rdata),
        .mem_addr_o (mem_addr),
        .mem_ce_n_o (mem_ce_n),
        .mem_oe_n_o (mem_oe_n),
        .mem_data_i (mem_data)
    );

    function automatic logic [7:0] pat(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // Memory model: true byte only once both access windows have elapsed.
    int m_ce_cnt = 0, m_oe_cnt = 0;
    always @(negedge clk) begin
        m_ce_cnt = (mem_ce_n != 4'hF) ? m_ce_cnt + 1 : 0;
        m_oe_cnt = (!mem_oe_n) ? m_oe_cnt + 1 : 0;
    end

    always @* begin
        logic [1:0] idx;
        idx = 2'd0;
        for (int i = 0; i < 4; i++) if (!mem_ce_n[i]) idx = 2'(i);
        if ($countones(~mem_ce_n) == 1 && !mem_oe_n) begin
            if (m_ce_cnt >= ACC && m_oe_cnt >= OE) mem_data = pat({idx, mem_addr});
            else mem_data = ~pat({idx, mem_addr});
        end else begin
            mem_data = 8'h00;
        end
    end

    // Scoreboard
    logic [19:0] exp_q[$];

    task automatic rd(input logic [19:0] a, input bit keep);
        exp_q.push_back(a);
        addr = a;
        req  = 1'b1;
        do @(negedge clk); while (!ack);
        if (!keep) req = 1'b0;
    endtask

    // Monitor
    bit          prev_act = 0, seen_one = 0, req_all = 0;
    int          lowcnt = 0, oe_at = -1, hicnt = 0;
    logic [3:0]  sel_s;
    logic [17:0] ma_s;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit act;
            act = (mem_ce_n != 4'hF);
            if (act) begin
                if (!prev_act) begin
                    if (seen_one) begin
                        chk(hicnt >= FLT + 1, "R7", "min float gap", hicnt, FLT + 1);
                        if (req_all) chk(hicnt == FLT + 1, "R7", "exact float gap", hicnt, FLT + 1);
                    end
                    lowcnt = 0;
                    oe_at  = -1;
                    sel_s  = mem_ce_n;
                    ma_s   = mem_addr;
                    chk($countones(~mem_ce_n) == 1, "R2", "single enable", mem_ce_n, 0);
                end else begin
                    chk(mem_ce_n == sel_s && mem_addr == ma_s, "R2", "hold during access",
                        {mem_ce_n, mem_addr}, {sel_s, ma_s});
                end
                lowcnt++;
                if (!mem_oe_n && oe_at < 0) oe_at = lowcnt - 1;
                if (mem_oe_n && oe_at >= 0) chk(0, "R6", "oe rose before ce", 1, 0);
            end else begin
                if (prev_act) begin
                    hicnt = 1; req_all = 1; seen_one = 1;
                end else begin
                    hicnt++;
                    if (!req) req_all = 0;
                end
                if (!mem_oe_n) chk(0, "R4", "oe low without ce", 0, 1);
            end
            if (ack) begin
                logic [19:0] e;
                logic [1:0]  dv;
                chk(prev_act && !act && mem_oe_n, "R6", "release at capture", act, 0);
                chk(lowcnt == CAP, "R5", "capture cycle (R3 rounding)", lowcnt, CAP);
                chk(oe_at == GATE, "R4", "oe delay", oe_at, GATE);
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "ack without request", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    dv = 2'd0;
                    for (int i = 0; i < 4; i++) if (!sel_s[i]) dv = 2'(i);
                    chk(rdata == pat(e), "R5", "read data", rdata, pat(e));
                    chk(dv == e[19:18], "R2", "device select", dv, e[19:18]);
                    chk(ma_s == e[17:0], "R2", "memory address", ma_s, e[17:0]);
                end
            end
            prev_act = act;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        chk(0, "ALL", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1
        chk(mem_ce_n == 4'hF && mem_oe_n && !ack, "R1", "reset outputs",
            {mem_ce_n, mem_oe_n, ack}, 6'b111110);
        rst_n = 1'b1;
        // R9: no request, no enables
        repeat (12) begin
            @(negedge clk);
            chk(mem_ce_n == 4'hF && mem_oe_n, "R9", "idle enables", {mem_ce_n, mem_oe_n}, 5'h1F);
        end
        rd(20'h00000, 0); repeat (3) @(negedge clk);
        rd(20'h3FFFF, 0); repeat (2) @(negedge clk);
        rd(20'h40000, 0); repeat (7) @(negedge clk);
        rd(20'h7FFFF, 0);
        rd(20'h80123, 0); repeat (1) @(negedge clk);
        rd(20'hBFFFE, 0);
        rd(20'hC0ABC, 0); repeat (4) @(negedge clk);
        rd(20'hFFFFF, 0); repeat (2) @(negedge clk);
        // Back-to-back burst across devices
        rd(20'h12345, 1);
        rd(20'h5A5A5, 1);
        rd(20'hA0001, 1);
        rd(20'hE7654, 1);
        rd(20'h01010, 1);
        rd(20'hC3C3C, 0);
        // R8: result and address hold while idle
        repeat (15) begin
            @(negedge clk);
            chk(rdata == pat(20'hC3C3C), "R8", "rdata hold", rdata, pat(20'hC3C3C));
            chk(mem_addr == 18'h3C3C, "R8", "address hold", mem_addr, 18'h3C3C);
        end
        chk(exp_q.size() == 0, "R5", "all reads acknowledged", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule